// File: doc/BRIEF.md
# Serial Management PHY Register Responder

This block sits on the slave side of a two-wire serial management bus and plays the part of a PHY's management register file. It watches the management clock and data line and decodes standard read and write frames. Frames carry a 5-bit device address and a 5-bit register index, and the block answers only those that carry its own configured address. Reads come back on the shared data line after a turnaround. Writes land in a 32-entry, 16-bit register array.

Most registers return what was last stored in them. Four status-type registers are built at read time from the `link_up` input and the advertisement register, so the modelled PHY always reports a partner that agrees with the best mode on offer. The management clock and data are sampled with the system clock through synchronisers. Every field is taken on a rising edge of the management clock.

Top module: `mdio_phy_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 (advertisement) reads 0x01E1, and every other stored register reads 0x0000.
- R2: Register 1 reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) while `link_up` is high and 0x0000 while it is low, whatever was written to it.
- R3: Register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001, independent of link state.
- R4: Register 17 always reads 0x8000.
- R5: While the link is up, register 18 reads bit 10 = adv[7] OR adv[8] and bit 11 = adv[8] OR adv[6], other bits zero; while the link is down it reads 0x0000.
- R6: A matched write stores its 16-bit data, and every register other than 1, 5, 17 and 18 reads back the last value written.
- R7: A frame is accepted only after at least 32 consecutive ones followed by start bits 0 then 1. A frame preceded by 31 ones, or by a bad start pattern, has no effect.
- R8: On a matched read (opcode bits 1 then 0), the line is released during the first turnaround bit. The block drives 0 during the second, then drives the 16 data bits MSB first, which is 17 driven bit times in all, and then releases the line.
- R9: A frame whose device address differs from `cfg_phy_addr` is never driven on. A read of it sees the pulled-up line, 0xFFFF, and a write to it changes no register.
- R10: Opcodes 00 and 11 are ignored: no drive and no store.
- R11: A write (opcode bits 0 then 1) stores only if its turnaround bits are 1 then 0. Any other turnaround discards the frame.
- R12: `mdio_oe` is low after reset, the block never drives while the master drives, and `mdio_oe`/`mdio_out` change only in the cycle after a sampled management clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the management bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phy_addr | input | 5 | Device address this responder answers to |
| link_up | input | 1 | Link state folded into the computed status reads |
| mdc | input | 1 | Management clock from the bus master |
| mdio_in | input | 1 | Resolved level of the shared management data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line |

## Verification
A read is swept over all 32 registers straight after reset, and again after a write pass that puts a distinct arithmetic pattern into every index. This separates stored registers from computed ones and finds any stuck or aliased index. The advertisement register is swept through all 16 combinations of its mode bits, with the partner and diagnostic reads checked against formulas in the bench, and the link input is toggled to show the gating of the status and diagnostic reads. Every device address is also read once, which separates the single matching address (driven, correct turnaround) from the 31 others (never driven, 0xFFFF). Frames with 31 preamble bits, a bad start pattern, a reserved opcode or a bad write turnaround are each followed by a read that shows nothing was stored.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    localparam int DATA_W   = 16;
    localparam int IDX_W    = 5;
    localparam int ADDR_W   = 5;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int PRE_LEN  = 32;
    localparam int CNT_W    = $clog2(PRE_LEN + 1);

    // register indices with special read behaviour or reset values
    localparam logic [IDX_W-1:0] IDX_CTRL    = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ID_HI   = 5'd2;
    localparam logic [IDX_W-1:0] IDX_ID_LO   = 5'd3;
    localparam logic [IDX_W-1:0] IDX_ADV     = 5'd4;
    localparam logic [IDX_W-1:0] IDX_PARTNER = 5'd5;
    localparam logic [IDX_W-1:0] IDX_SPEED   = 5'd17;
    localparam logic [IDX_W-1:0] IDX_DIAG    = 5'd18;

    // computed read values
    localparam logic [DATA_W-1:0] STATUS_UP   = 16'h7800 | 16'h0020 | 16'h0008 | 16'h0006;
    localparam logic [DATA_W-1:0] PARTNER_ACK = 16'h4000;
    localparam logic [DATA_W-1:0] PARTNER_AN  = 16'h0001;
    localparam logic [DATA_W-1:0] ADV_MODES   = 16'h01E0;
    localparam logic [DATA_W-1:0] SPEED_GIG   = 16'h8000;
    localparam int ADV_10FD   = 6;
    localparam int ADV_100HD  = 7;
    localparam int ADV_100FD  = 8;
    localparam int DIAG_100   = 10;
    localparam int DIAG_FULL  = 11;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef enum logic [2:0] {
        PH_PRE,
        PH_SOF,
        PH_OP,
        PH_PHY,
        PH_REG,
        PH_TA,
        PH_DATA
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic                op_rd;
        logic [ADDR_W-1:0]   phy;
        logic [IDX_W-1:0]    regi;
        logic [DATA_W-1:0]   shreg;
        logic                drive;
        logic                dout;
        logic                wr_en;
    } frame_st_t;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_line_sync.sv
module mdio_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdio_smp
);

    logic [STAGES:0]   mdc_d, mdc_q;
    logic [STAGES-1:0] dat_d, dat_q;

    always_comb begin
        mdc_d = {mdc_q[STAGES-1:0], mdc_i};
    end

    generate
        if (STAGES == 1) begin : g_single
            always_comb dat_d = mdio_i;
        end else begin : g_chain
            always_comb dat_d = {dat_q[STAGES-2:0], mdio_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q <= '0;
            dat_q <= '0;
        end else begin
            mdc_q <= mdc_d;
            dat_q <= dat_d;
        end
    end

    assign mdc_rise = mdc_q[STAGES-1] & ~mdc_q[STAGES];
    assign mdio_smp = dat_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] cfg_phy_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] frame_phy,
    output logic              mdio_oe,
    output logic              mdio_out
);

    localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] PHY_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(IDX_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

    frame_st_t st_d, st_q;
    logic      matched;

    // index of the register being addressed, complete on the last index bit
    assign rd_idx  = {st_q.regi[IDX_W-2:0], bit_in};
    assign matched = (st_q.phy == cfg_phy_addr);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (bit_valid) begin
            unique case (st_q.phase)
                PH_PRE: begin
                    if (bit_in) begin
                        if (st_q.cnt != PRE_CNT) st_d.cnt = st_q.cnt + 1'b1;
                    end else begin
                        st_d.cnt = '0;
                        if (st_q.cnt == PRE_CNT) st_d.phase = PH_SOF;
                    end
                end
                PH_SOF: begin
                    st_d.cnt   = '0;
                    st_d.phase = bit_in ? PH_OP : PH_PRE;
                end
                PH_OP: begin
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], bit_in};
                    if (st_q.cnt == '0) begin
                        st_d.cnt = CNT_W'(1);
                    end else begin
                        st_d.cnt = '0;
                        unique case ({st_q.shreg[0], bit_in})
                            OPC_READ: begin
                                st_d.op_rd = 1'b1;
                                st_d.phase = PH_PHY;
                            end
                            OPC_WRITE: begin
                                st_d.op_rd = 1'b0;
                                st_d.phase = PH_PHY;
                            end
                            default: st_d.phase = PH_PRE;
                        endcase
                    end
                end
                PH_PHY: begin
                    st_d.phy = {st_q.phy[ADDR_W-2:0], bit_in};
                    if (st_q.cnt == PHY_LAST) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_REG;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_REG: begin
                    st_d.regi = rd_idx;
                    if (st_q.cnt == REG_LAST) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_TA;
                        if (st_q.op_rd && matched) st_d.shreg = rd_data;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_TA: begin
                    if (st_q.cnt == '0) begin
                        // first turnaround bit: line released, take it for the second
                        st_d.cnt = CNT_W'(1);
                        if (st_q.op_rd) begin
                            if (matched) begin
                                st_d.drive = 1'b1;
                                st_d.dout  = 1'b0;
                            end
                        end else if (!bit_in) begin
                            st_d.cnt   = '0;
                            st_d.phase = PH_PRE;
                        end
                    end else begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_DATA;
                        if (st_q.op_rd) begin
                            if (matched) begin
                                st_d.dout  = st_q.shreg[DATA_W-1];
                                st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                            end
                        end else if (bit_in) begin
                            st_d.phase = PH_PRE;
                        end
                    end
                end
                PH_DATA: begin
                    if (st_q.op_rd) begin
                        if (st_q.cnt == DAT_LAST) begin
                            st_d.drive = 1'b0;
                            st_d.dout  = 1'b0;
                            st_d.cnt   = '0;
                            st_d.phase = PH_PRE;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                            if (st_q.drive) begin
                                st_d.dout  = st_q.shreg[DATA_W-1];
                                st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        st_d.shreg = {st_q.shreg[DATA_W-2:0], bit_in};
                        if (st_q.cnt == DAT_LAST) begin
                            st_d.wr_en = matched;
                            st_d.cnt   = '0;
                            st_d.phase = PH_PRE;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_PRE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_PRE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en     = st_q.wr_en;
    assign wr_idx    = st_q.regi;
    assign wr_data   = st_q.shreg;
    assign frame_phy = st_q.phy;
    assign mdio_oe   = st_q.drive;
    assign mdio_out  = st_q.dout;

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
    import mdio_resp_pkg::*;
#(
    parameter int NREG = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] adv;
    logic              adv_100, adv_full;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= reset_value(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign adv      = regs_q[IDX_ADV];
    assign adv_100  = adv[ADV_100HD] | adv[ADV_100FD];
    assign adv_full = adv[ADV_100FD] | adv[ADV_10FD];

    always_comb begin
        unique case (rd_idx)
            IDX_STATUS:  rd_data = link_up ? STATUS_UP : '0;
            IDX_PARTNER: rd_data = PARTNER_ACK | (adv & ADV_MODES) | PARTNER_AN;
            IDX_SPEED:   rd_data = SPEED_GIG;
            IDX_DIAG: begin
                rd_data = '0;
                if (link_up) begin
                    rd_data[DIAG_100]  = adv_100;
                    rd_data[DIAG_FULL] = adv_full;
                end
            end
            default:     rd_data = regs_q[rd_idx];
        endcase
    end

endmodule

// File: rtl/mdio_phy_responder.sv
module mdio_phy_responder
    import mdio_resp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_phy_addr,
    input  logic              link_up,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic              mdc_rise;
    logic              mdio_smp;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] frame_phy;

    mdio_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_i    (mdc),
        .mdio_i   (mdio_in),
        .mdc_rise (mdc_rise),
        .mdio_smp (mdio_smp)
    );

    mdio_frame_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_valid    (mdc_rise),
        .bit_in       (mdio_smp),
        .cfg_phy_addr (cfg_phy_addr),
        .rd_data      (rd_data),
        .rd_idx       (rd_idx),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .frame_phy    (frame_phy),
        .mdio_oe      (mdio_oe),
        .mdio_out     (mdio_out)
    );

    mdio_phy_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/mdio_phy_responder_chk.sv
module mdio_phy_responder_chk
    import mdio_resp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mdc_rise,
    input logic              mdio_oe,
    input logic              mdio_out,
    input logic [ADDR_W-1:0] frame_phy,
    input logic [ADDR_W-1:0] cfg_phy_addr
);

    localparam int WIN = DATA_W + 1;

    logic [5:0] drive_bits;

    // number of bit times the line has been driven in the current window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            drive_bits <= '0;
        else if (!mdio_oe)     drive_bits <= '0;
        else if (mdc_rise)     drive_bits <= drive_bits + 1'b1;
    end

    p_first_drive_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    p_window_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_bits <= 6'(WIN));

    p_drive_only_matched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (frame_phy == cfg_phy_addr));

    p_oe_on_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $past(mdc_rise));

    p_out_on_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && !$stable(mdio_out)) |-> $past(mdc_rise));

endmodule

bind mdio_phy_responder mdio_phy_responder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mdc_rise     (mdc_rise),
    .mdio_oe      (mdio_oe),
    .mdio_out     (mdio_out),
    .frame_phy    (frame_phy),
    .cfg_phy_addr (cfg_phy_addr)
);

// File: tb/mdio_phy_responder_tb.sv
module mdio_phy_responder_tb;

    localparam int HALF = 4;
    localparam logic [4:0] MY_PHY = 5'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_up = 1'b1;
    logic       mdc = 1'b0;
    logic       m_oe = 1'b0;
    logic       m_drv = 1'b1;
    logic       mdio_out, mdio_oe;
    logic       mdio_line;

    int n_checks = 0;
    int n_fail = 0;
    int conflicts = 0;
    bit done = 0;
    logic [15:0] exp_regs [32];

    always #10 clk = ~clk;

    // wired bus with pull-up
    assign mdio_line = mdio_oe ? mdio_out : (m_oe ? m_drv : 1'b1);

    mdio_phy_responder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_phy_addr (MY_PHY),
        .link_up      (link_up),
        .mdc          (mdc),
        .mdio_in      (mdio_line),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input int idx);
        logic [15:0] a;
        a = exp_regs[4];
        case (idx)
            1:  return link_up ? 16'h782E : 16'h0000;
            5:  return 16'h4000 | (a & 16'h01E0) | 16'h0001;
            17: return 16'h8000;
            18: return link_up ? 16'((int'(a[7] | a[8]) << 10) | (int'(a[8] | a[6]) << 11))
                               : 16'h0000;
            default: return exp_regs[idx];
        endcase
    endfunction

    task automatic mbit(input bit drv, input bit v, output bit smp, output bit oe);
        m_oe  = drv;
        m_drv = v;
        mdc   = 1'b0;
        repeat (HALF) @(negedge clk);
        smp = mdio_line;
        oe  = mdio_oe;
        if (drv && mdio_oe) conflicts++;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_frame(input int pre_n, input logic [1:0] sof, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg, input bit rd,
                            input logic [1:0] ta, input logic [15:0] wd,
                            output logic [15:0] rdat, output int drv_cnt,
                            output bit ta1_oe, output bit ta2_val);
        bit s, o;
        drv_cnt = 0; rdat = '0; ta1_oe = 0; ta2_val = 1;
        for (int i = 0; i < pre_n; i++) begin mbit(1, 1, s, o); drv_cnt += int'(o); end
        for (int i = 1; i >= 0; i--) begin mbit(1, sof[i], s, o); drv_cnt += int'(o); end
        for (int i = 1; i >= 0; i--) begin mbit(1, op[i], s, o); drv_cnt += int'(o); end
        for (int i = 4; i >= 0; i--) begin mbit(1, phy[i], s, o); drv_cnt += int'(o); end
        for (int i = 4; i >= 0; i--) begin mbit(1, rg[i], s, o); drv_cnt += int'(o); end
        if (rd) begin
            for (int i = 0; i < 18; i++) begin
                mbit(0, 1, s, o);
                drv_cnt += int'(o);
                if (i == 0)      ta1_oe = o;
                else if (i == 1) ta2_val = s;
                else             rdat = {rdat[14:0], s};
            end
        end else begin
            for (int i = 1; i >= 0; i--) begin mbit(1, ta[i], s, o); drv_cnt += int'(o); end
            for (int i = 15; i >= 0; i--) begin mbit(1, wd[i], s, o); drv_cnt += int'(o); end
        end
        m_oe = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] exp, input bit full);
        logic [15:0] d; int dc; bit t1, t2;
        do_frame(32, 2'b01, 2'b10, phy, rg, 1, 2'b00, 16'h0, d, dc, t1, t2);
        check(req, $sformatf("read phy %0d reg %0d data", phy, rg), 32'(d), 32'(exp));
        if (full) begin
            check("R8", "driven bit count", 32'(dc), (phy == MY_PHY) ? 32'd17 : 32'd0);
            check("R8", "first turnaround released", 32'(t1), 32'd0);
            check("R8", "second turnaround level", 32'(t2), (phy == MY_PHY) ? 32'd0 : 32'd1);
        end
    endtask

    task automatic wr(input int pre_n, input logic [1:0] sof, input logic [1:0] op,
                      input logic [4:0] phy, input logic [4:0] rg,
                      input logic [1:0] ta, input logic [15:0] v);
        logic [15:0] d; int dc; bit t1, t2;
        do_frame(pre_n, sof, op, phy, rg, 0, ta, v, d, dc, t1, t2);
    endtask

    initial begin
        logic [15:0] d; int dc; bit t1, t2; bit s, o;
        for (int i = 0; i < 32; i++) exp_regs[i] = 16'h0000;
        exp_regs[0] = 16'h3100; exp_regs[2] = 16'h0300;
        exp_regs[3] = 16'hE400; exp_regs[4] = 16'h01E1;

        repeat (5) @(negedge clk);
        check("R12", "oe during reset", 32'(mdio_oe), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12", "oe after reset", 32'(mdio_oe), 32'd0);

        // R1 R2 R3 R4 R5: reset sweep of all registers
        for (int i = 0; i < 32; i++) rd_chk("R1", MY_PHY, 5'(i), exp_read(i), i == 0);
        check("R2", "status with link up", 32'(exp_read(1)), 32'h782E);

        // R9: every device address
        for (int p = 0; p < 32; p++)
            rd_chk("R9", 5'(p), 5'd2, (p == int'(MY_PHY)) ? 16'h0300 : 16'hFFFF, 1);

        // R6: write every register with a distinct pattern, read all back
        for (int i = 0; i < 32; i++) begin
            logic [15:0] v;
            v = 16'((i * 16'h1357) ^ 16'hA5A5);
            wr(32, 2'b01, 2'b01, MY_PHY, 5'(i), 2'b10, v);
            exp_regs[i] = v;
        end
        for (int i = 0; i < 32; i++) rd_chk("R6", MY_PHY, 5'(i), exp_read(i), 0);

        // R3 R5: advertisement sweep
        for (int m = 0; m < 16; m++) begin
            logic [15:0] a;
            a = 16'((m << 5) | 1);
            wr(32, 2'b01, 2'b01, MY_PHY, 5'd4, 2'b10, a);
            exp_regs[4] = a;
            rd_chk("R3", MY_PHY, 5'd5, exp_read(5), 0);
            rd_chk("R5", MY_PHY, 5'd18, exp_read(18), 0);
        end

        // R2 R5: link down
        link_up = 1'b0;
        rd_chk("R2", MY_PHY, 5'd1, 16'h0000, 0);
        rd_chk("R5", MY_PHY, 5'd18, 16'h0000, 0);
        rd_chk("R3", MY_PHY, 5'd5, exp_read(5), 0);
        rd_chk("R4", MY_PHY, 5'd17, 16'h8000, 0);
        link_up = 1'b1;
        rd_chk("R2", MY_PHY, 5'd1, 16'h782E, 0);

        // R9: write to another address leaves register 0 untouched
        wr(32, 2'b01, 2'b01, 5'd8, 5'd0, 2'b10, 16'h1234);
        rd_chk("R9", MY_PHY, 5'd0, exp_regs[0], 0);

        // R7: short preamble and bad start pattern
        wr(31, 2'b01, 2'b01, MY_PHY, 5'd9, 2'b10, 16'h0000);
        rd_chk("R7", MY_PHY, 5'd9, exp_regs[9], 0);
        wr(32, 2'b00, 2'b01, MY_PHY, 5'd9, 2'b10, 16'h0000);
        rd_chk("R7", MY_PHY, 5'd9, exp_regs[9], 0);

        // R10: reserved opcodes
        do_frame(32, 2'b01, 2'b11, MY_PHY, 5'd2, 1, 2'b00, 16'h0, d, dc, t1, t2);
        check("R10", "opcode 11 drive count", 32'(dc), 32'd0);
        check("R10", "opcode 11 data", 32'(d), 32'hFFFF);
        wr(32, 2'b01, 2'b00, MY_PHY, 5'd10, 2'b10, 16'h0000);
        rd_chk("R10", MY_PHY, 5'd10, exp_regs[10], 0);

        // R11: bad write turnaround
        wr(32, 2'b01, 2'b01, MY_PHY, 5'd11, 2'b00, 16'h0000);
        rd_chk("R11", MY_PHY, 5'd11, exp_regs[11], 0);
        wr(32, 2'b01, 2'b01, MY_PHY, 5'd11, 2'b11, 16'h0000);
        rd_chk("R11", MY_PHY, 5'd11, exp_regs[11], 0);
        wr(32, 2'b01, 2'b01, MY_PHY, 5'd11, 2'b10, 16'h0F0F);
        exp_regs[11] = 16'h0F0F;
        rd_chk("R6", MY_PHY, 5'd11, exp_regs[11], 1);

        // R12: idle after frames, no bus fight seen at any time
        mbit(0, 1, s, o);
        check("R12", "oe idle after read", 32'(o), 32'd0);
        check("R12", "bus conflicts", 32'(conflicts), 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule